// File: doc/BRIEF.md
# Dual Multi-Mode Counter/Timer

This block holds two byte-oriented counter/timers. They share one mode byte, one run/flag byte and one tick-select byte, all written through a plain byte-wide write port and read back through an asynchronous read port. Each timer keeps a low and a high count byte. A timer counts one of two sources. The first is a system-clock tick, taken either on every cycle or once every twelve cycles from a shared free-running prescaler. The second is a falling edge on its external count pin, taken through a synchronizer.

Each timer can count as a 13-bit counter, a 16-bit counter, or an 8-bit counter that reloads from its high byte. Timer 0 can also split into two independent 8-bit counters. An active-high gate input can hold a running timer. On overflow the timer sets a sticky flag and raises a one-cycle pulse. The flag drives the interrupt request. Software can clear the flag with a write of 0, and an acknowledge input from the interrupt controller also clears it.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset every readable address (0 to 7) returns 00h, and `irq` and `ovfPulse` are 0.
- R2: The address map is as follows. Address 0 is the mode byte. Address 1 is the run/flag byte, with bit 7 flag1, bit 6 run1, bit 5 flag0, bit 4 run0 and bits 3:0 reading 0. Address 2 is the tick-select byte, with bit 0 for timer 0, bit 1 for timer 1 and the other bits reading 0. Addresses 3, 4, 5 and 6 are the low 0, high 0, low 1 and high 1 count bytes. Address 7 reads 0. Written values read back.
- R3: With the counter-select bit at 0, a timer whose tick-select bit is 1 advances on every cycle. With the tick-select bit at 0 it advances exactly 10 times in any 120 consecutive cycles.
- R4: A timer advances only while its run bit is 1 and either its gate bit is 0 or its `gateIn` bit is 1. When it does not advance, its count bytes hold.
- R5: Mode 01 gives a 16-bit count {high, low}. Stepping from FFFFh gives 0000h and sets the flag.
- R6: In mode 00 the low 5 bits of the low byte carry into the high byte, and bits 7:5 of the low byte hold. Stepping from high FFh with low bits 1Fh clears the 13-bit count and sets the flag.
- R7: In mode 10 the low byte counts. When it steps from FFh it takes the high byte's value and sets the flag. The high byte is unchanged.
- R8: Mode 11 on timer 0 makes its low byte an 8-bit counter under run0, gate0 and flag0. The high byte then counts the timer 0 tick source under run1 alone and sets flag1, and an overflow of timer 1 does not set flag1. Mode 11 on timer 1 freezes timer 1.
- R9: With the counter-select bit at 1, a timer counts exactly one step per high-to-low transition of its `cntPin` bit. A count lands three cycles after the pin falls.
- R10: An overflow sets the flag at the same edge that updates the count. `ovfPulse` is high for exactly the following cycle. `irq` equals the flags.
- R11: A write of 0 to a flag bit clears it, and so does `intAck` for that timer. An overflow in the same cycle as an acknowledge leaves the flag set.

Mode byte: bit 7 gate1, bit 6 counter-select 1, bits 5:4 mode 1, bit 3 gate0, bit 2 counter-select 0, bits 1:0 mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data (combinational) |
| gateIn | input | 2 | Active-high gate level per timer |
| cntPin | input | 2 | External count pin per timer |
| intAck | input | 2 | Interrupt acknowledge per timer |
| irq | output | 2 | Interrupt request (overflow flags) |
| ovfPulse | output | 2 | One-cycle flag-set pulse per timer |

## Verification
The hardest case to reach from the ports is an overflow that lands in the very cycle an acknowledge arrives. The flag must then stay set. To reach it, the bench preloads FFFFh in 16-bit mode with the per-cycle tick. It starts the timer and holds `intAck` across the single edge on which the count wraps, then releases it one cycle later to see the clear. The exact-rate check of the divided tick uses a 120-cycle window, so the result does not depend on the phase of the shared prescaler. Randomized mode, start and reload values are compared against a bench step model.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;   // low-byte prescaler width in 13-bit mode

  localparam logic [2:0] ADR_MODE = 3'd0;
  localparam logic [2:0] ADR_CTRL = 3'd1;
  localparam logic [2:0] ADR_TSEL = 3'd2;
  localparam logic [2:0] ADR_LO0  = 3'd3;
  localparam logic [2:0] ADR_HI0  = 3'd4;
  localparam logic [2:0] ADR_LO1  = 3'd5;
  localparam logic [2:0] ADR_HI1  = 3'd6;

  typedef enum logic [1:0] {
    CNT13   = 2'b00,
    CNT16   = 2'b01,
    RELOAD8 = 2'b10,
    SPLIT8  = 2'b11
  } cntModeT;

  typedef struct packed {
    logic [1:0] stepMain;  // advance the main counter of each timer
    logic       stepHi0;   // advance timer 0 high byte in split mode
    logic [3:0] wrByte;    // lo0, hi0, lo1, hi1 load strobes
    cntModeT    mode0;
    cntModeT    mode1;
  } ctlT;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/timer_control.sv
module timer_control
  import timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [1:0]        gateIn,
  input  logic [1:0]        cntPin,
  input  logic [1:0]        intAck,
  input  logic              divTick,
  input  logic [1:0]        ovfMain,
  input  logic              ovfHi0,
  output ctlT               ctl,
  output logic [BYTE_W-1:0] modeReg,
  output logic [1:0]        runBits,
  output logic [1:0]        flagBits,
  output logic [1:0]        tickSel,
  output logic [1:0]        ovfPulse
);
  logic [1:0][SYNC_STAGES-1:0] syncQ;
  logic [1:0] prevQ, pinFall, tickSrc, runOk, gateBit, ctSel, setFlag, flagNext;
  logic wrCtrl;

  // Pin synchronizer and falling-edge detect, idle level high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '1;
      prevQ <= '1;
    end else begin
      for (int p = 0; p < 2; p++) begin
        syncQ[p] <= {syncQ[p][SYNC_STAGES-2:0], cntPin[p]};
        prevQ[p] <= syncQ[p][SYNC_STAGES-1];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < 2; p++) pinFall[p] = prevQ[p] & ~syncQ[p][SYNC_STAGES-1];
  end

  assign gateBit = {modeReg[7], modeReg[3]};
  assign ctSel   = {modeReg[6], modeReg[2]};

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      tickSrc[t] = ctSel[t] ? pinFall[t] : (tickSel[t] | divTick);
      runOk[t]   = runBits[t] & (~gateBit[t] | gateIn[t]);
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.mode0    = cntModeT'(modeReg[1:0]);
    ctl.mode1    = cntModeT'(modeReg[5:4]);
    ctl.stepMain[0] = runOk[0] & tickSrc[0];
    ctl.stepMain[1] = runOk[1] & tickSrc[1] & (ctl.mode1 != SPLIT8);
    ctl.stepHi0  = (ctl.mode0 == SPLIT8) & runBits[1] & (tickSel[0] | divTick);
    ctl.wrByte[0] = wrEn & (wrAddr == ADR_LO0);
    ctl.wrByte[1] = wrEn & (wrAddr == ADR_HI0);
    ctl.wrByte[2] = wrEn & (wrAddr == ADR_LO1);
    ctl.wrByte[3] = wrEn & (wrAddr == ADR_HI1);
  end

  assign wrCtrl     = wrEn & (wrAddr == ADR_CTRL);
  assign setFlag[0] = ovfMain[0];
  assign setFlag[1] = (ctl.mode0 == SPLIT8) ? ovfHi0 : ovfMain[1];

  always_comb begin
    flagNext = wrCtrl ? {wrData[7], wrData[5]} : flagBits;
    flagNext = (flagNext & ~intAck) | setFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= '0;
      runBits  <= '0;
      flagBits <= '0;
      tickSel  <= '0;
      ovfPulse <= '0;
    end else begin
      if (wrEn && wrAddr == ADR_MODE) modeReg <= wrData;
      if (wrEn && wrAddr == ADR_TSEL) tickSel <= wrData[1:0];
      if (wrCtrl) runBits <= {wrData[6], wrData[4]};
      flagBits <= flagNext;
      ovfPulse <= setFlag;
    end
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlT                    ctl,
  input  logic [BYTE_W-1:0]      wrData,
  output logic [1:0][BYTE_W-1:0] loBytes,
  output logic [1:0][BYTE_W-1:0] hiBytes,
  output logic [1:0]             ovfMain,
  output logic                   ovfHi0
);
  localparam logic [2*BYTE_W-1:0] ONE_W = 1;

  for (genvar t = 0; t < 2; t++) begin : g_unit
    logic [BYTE_W-1:0] loR, hiR, loN, hiN;
    logic ovf;
    cntModeT m;

    assign m = (t == 0) ? ctl.mode0 : ctl.mode1;

    always_comb begin
      loN = loR;
      hiN = hiR;
      ovf = 1'b0;
      if (ctl.stepMain[t]) begin
        unique case (m)
          CNT13: begin
            loN[PRE_W-1:0] = loR[PRE_W-1:0] + 1'b1;
            if (&loR[PRE_W-1:0]) begin
              hiN = hiR + 1'b1;
              ovf = &hiR;
            end
          end
          CNT16: begin
            {hiN, loN} = {hiR, loR} + ONE_W;
            ovf = &{hiR, loR};
          end
          RELOAD8: begin
            if (&loR) begin
              loN = hiR;
              ovf = 1'b1;
            end else begin
              loN = loR + 1'b1;
            end
          end
          default: begin
            loN = loR + 1'b1;
            ovf = &loR;
          end
        endcase
      end
      if (t == 0 && ctl.stepHi0) hiN = hiR + 1'b1;
      if (ctl.wrByte[2*t])       loN = wrData;
      if (ctl.wrByte[2*t+1])     hiN = wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loR <= '0;
        hiR <= '0;
      end else begin
        loR <= loN;
        hiR <= hiN;
      end
    end

    assign loBytes[t] = loR;
    assign hiBytes[t] = hiR;
    assign ovfMain[t] = ovf;
  end

  assign ovfHi0 = ctl.stepHi0 & (&hiBytes[0]);
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import timer_pkg::*;
#(
  parameter int PRESCALE_DIV = 12,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData,
  input  logic [1:0] gateIn,
  input  logic [1:0] cntPin,
  input  logic [1:0] intAck,
  output logic [1:0] irq,
  output logic [1:0] ovfPulse
);
  ctlT ctl;
  logic divTick, ovfHi0;
  logic [1:0] ovfMain, runBits, flagBits, tickSel;
  logic [BYTE_W-1:0] modeReg;
  logic [1:0][BYTE_W-1:0] loBytes, hiBytes;

  timer_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk(clk), .rstN(rstN), .tick(divTick)
  );

  timer_control #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .gateIn(gateIn), .cntPin(cntPin), .intAck(intAck), .divTick(divTick),
    .ovfMain(ovfMain), .ovfHi0(ovfHi0), .ctl(ctl), .modeReg(modeReg),
    .runBits(runBits), .flagBits(flagBits), .tickSel(tickSel), .ovfPulse(ovfPulse)
  );

  timer_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .loBytes(loBytes), .hiBytes(hiBytes), .ovfMain(ovfMain), .ovfHi0(ovfHi0)
  );

  assign irq = flagBits;

  always_comb begin
    unique case (rdAddr)
      ADR_MODE: rdData = modeReg;
      ADR_CTRL: rdData = {flagBits[1], runBits[1], flagBits[0], runBits[0], 4'b0000};
      ADR_TSEL: rdData = {6'b000000, tickSel};
      ADR_LO0:  rdData = loBytes[0];
      ADR_HI0:  rdData = hiBytes[0];
      ADR_LO1:  rdData = loBytes[1];
      ADR_HI1:  rdData = hiBytes[1];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/timer_checker.sv
module timer_checker (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [7:0]       modeReg,
  input logic [1:0]       runBits,
  input logic [1:0][7:0]  loBytes,
  input logic [1:0][7:0]  hiBytes,
  input logic [1:0]       irq,
  input logic [1:0]       intAck,
  input logic [1:0]       ovfPulse
);
  // R11: an acknowledge clears the flag unless a new overflow lands with it
  a_r11_ack_clears0: assert property (@(posedge clk) disable iff (!rstN)
    intAck[0] |=> (!irq[0] || ovfPulse[0]));

  // R10: the flag-set pulse is always seen with the flag high
  a_r10_pulse_flag0: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse[0] |-> irq[0]);
  a_r10_pulse_flag1: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse[1] |-> irq[1]);

  // R4: timer 0 stopped and not split, no write: count holds
  a_r4_stopped_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!runBits[0] && !wrEn && modeReg[1:0] != 2'b11) |=> $stable({hiBytes[0], loBytes[0]}));

  // R8: timer 1 in mode 11 is frozen
  a_r8_t1_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[5:4] == 2'b11 && !wrEn) |=> $stable({hiBytes[1], loBytes[1]}));
endmodule

bind dual_mode_timer timer_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .modeReg(modeReg), .runBits(runBits),
  .loBytes(loBytes), .hiBytes(hiBytes), .irq(irq), .intAck(intAck), .ovfPulse(ovfPulse)
);

// File: tb/dual_mode_timer_tb.sv
`timescale 1ns/1ps
module dual_mode_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [1:0] gateIn = 2'b00;
  logic [1:0] cntPin = 2'b11;
  logic [1:0] intAck = 2'b00;
  logic [1:0] irq, ovfPulse;
  int checks = 0;
  int errors = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  dual_mode_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .gateIn(gateIn), .cntPin(cntPin),
    .intAck(intAck), .irq(irq), .ovfPulse(ovfPulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rdAddr = a;
    #0.4;
    d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Step model: returns {flag, hi, lo} after n steps in mode m (00, 01, 10)
  function automatic logic [16:0] stepModel(input logic [1:0] m, input logic [7:0] lo,
                                            input logic [7:0] hi, input int n);
    logic f = 1'b0;
    for (int i = 0; i < n; i++) begin
      case (m)
        2'b00: begin
          if (lo[4:0] == 5'h1F) begin
            lo[4:0] = 5'h00;
            if (hi == 8'hFF) f = 1'b1;
            hi = hi + 8'd1;
          end else lo[4:0] = lo[4:0] + 5'd1;
        end
        2'b01: begin
          if (lo == 8'hFF) begin
            lo = 8'h00;
            if (hi == 8'hFF) f = 1'b1;
            hi = hi + 8'd1;
          end else lo = lo + 8'd1;
        end
        default: begin
          if (lo == 8'hFF) begin lo = hi; f = 1'b1; end
          else lo = lo + 8'd1;
        end
      endcase
    end
    return {f, hi, lo};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [16:0] exp;
    idle(3);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 reset irq", irq, 0);
    chk("R1 reset pulse", ovfPulse, 0);
    @(negedge clk); rstN = 1'b1;

    // R2 register map
    wr(3'd0, 8'hA5); rd(3'd0, v); chk("R2 mode readback", v, 8'hA5);
    wr(3'd1, 8'h0F); rd(3'd1, v); chk("R2 ctrl low bits zero", v, 8'h00);
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R2 tsel width", v, 8'h03);
    wr(3'd5, 8'h3C); rd(3'd5, v); chk("R2 lo1 readback", v, 8'h3C);
    wr(3'd6, 8'hC3); rd(3'd6, v); chk("R2 hi1 readback", v, 8'hC3);
    rd(3'd7, v); chk("R2 addr7", v, 0);
    wr(3'd5, 8'h00); wr(3'd6, 8'h00);

    // R5 and R10: 16-bit wrap and pulse timing
    wr(3'd0, 8'h01); wr(3'd2, 8'h01);
    wr(3'd3, 8'hFE); wr(3'd4, 8'hFF);
    wr(3'd1, 8'h10);
    idle(1); chk("R10 no early pulse", ovfPulse[0], 0);
    idle(1);
    chk("R10 pulse at wrap", ovfPulse[0], 1);
    chk("R5 flag set", irq[0], 1);
    rd(3'd3, v); chk("R5 lo wrap", v, 8'h00);
    rd(3'd4, v); chk("R5 hi wrap", v, 8'h00);
    idle(1); chk("R10 pulse one cycle", ovfPulse[0], 0);
    chk("R10 flag sticky", irq[0], 1);
    wr(3'd1, 8'h20);
    @(negedge clk); intAck = 2'b01; @(negedge clk); intAck = 2'b00;
    chk("R11 ack clears", irq[0], 0);

    // R6: 13-bit carry and upper low bits held
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);
    wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    wr(3'd1, 8'h10); idle(1);
    rd(3'd3, v); chk("R6 lo upper held", v, 8'hE0);
    rd(3'd4, v); chk("R6 hi wrap", v, 8'h00);
    chk("R6 flag", irq[0], 1);

    // R7: reload from the high byte
    wr(3'd1, 8'h00); wr(3'd0, 8'h02);
    wr(3'd3, 8'hFE); wr(3'd4, 8'h80);
    wr(3'd1, 8'h10); idle(2);
    rd(3'd3, v); chk("R7 reload", v, 8'h80);
    chk("R7 flag", irq[0], 1);
    idle(3);
    rd(3'd3, v); chk("R7 count on", v, 8'h83);
    rd(3'd4, v); chk("R7 hi kept", v, 8'h80);

    // R8: split mode on timer 0
    wr(3'd1, 8'h00); wr(3'd0, 8'h03);
    wr(3'd3, 8'hFE); wr(3'd4, 8'hFF);
    wr(3'd5, 8'h00); wr(3'd6, 8'h00);
    wr(3'd1, 8'h50); idle(1);
    chk("R8 hi0 sets flag1", irq, 2'b10);
    rd(3'd4, v); chk("R8 hi0 wrap", v, 8'h00);
    idle(1);
    chk("R8 lo0 sets flag0", irq[0], 1);
    rd(3'd3, v); chk("R8 lo0 wrap", v, 8'h00);
    // R8: timer 1 in mode 11 frozen
    wr(3'd1, 8'h00); wr(3'd0, 8'h30);
    wr(3'd5, 8'h05); wr(3'd6, 8'h06);
    wr(3'd1, 8'h40); idle(10);
    rd(3'd5, v); chk("R8 t1 frozen lo", v, 8'h05);
    rd(3'd6, v); chk("R8 t1 frozen hi", v, 8'h06);

    // R3: divided tick rate
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd0, 8'h01);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    wr(3'd1, 8'h10); idle(120);
    rd(3'd3, v); chk("R3 div12 rate", v, 8'd10);

    // R4: gating
    wr(3'd1, 8'h00); wr(3'd2, 8'h01); wr(3'd0, 8'h09);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    wr(3'd1, 8'h10); idle(5);
    rd(3'd3, v); chk("R4 gated hold", v, 8'h00);
    gateIn = 2'b01; idle(5);
    rd(3'd3, v); chk("R4 gate open", v, 8'h05);
    gateIn = 2'b00;

    // R9: external pin counting
    wr(3'd1, 8'h00); wr(3'd0, 8'h05);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    wr(3'd1, 8'h10);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); cntPin[0] = 1'b0; idle(2);
      cntPin[0] = 1'b1; idle(3);
    end
    idle(4);
    rd(3'd3, v); chk("R9 pin edges", v, 8'd7);

    // R11: overflow coinciding with acknowledge, then write-zero clear
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'h01);
    wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    wr(3'd1, 8'h10);
    intAck = 2'b01; idle(1);
    chk("R11 set beats ack", irq[0], 1);
    idle(1); intAck = 2'b00;
    chk("R11 ack after set", irq[0], 0);
    wr(3'd1, 8'h30); chk("R11 sw set", irq[0], 1);
    wr(3'd1, 8'h10); chk("R11 write zero clears", irq[0], 0);

    // Random modes and values against the step model (R5 R6 R7)
    void'($urandom(32'd1234));
    wr(3'd1, 8'h00); wr(3'd2, 8'h03);
    for (int it = 0; it < 24; it++) begin
      int t, n;
      logic [1:0] m;
      logic [7:0] lo, hi;
      t  = $urandom_range(1, 0);
      m  = 2'($urandom_range(2, 0));
      lo = 8'($urandom);
      hi = 8'($urandom);
      n  = $urandom_range(400, 1);
      if (it == 0) begin lo = 8'hF0; hi = 8'hFF; m = 2'b01; n = 20; end
      wr(3'd0, 8'(m) << (4 * t));
      wr(3'(3 + 2 * t), lo);
      wr(3'(4 + 2 * t), hi);
      wr(3'd1, t == 1 ? 8'h40 : 8'h10);
      idle(n);
      exp = stepModel(m, lo, hi, n);
      rd(3'(3 + 2 * t), v); chk("R5 R6 R7 random lo", v, exp[7:0]);
      rd(3'(4 + 2 * t), v); chk("R5 R6 R7 random hi", v, exp[15:8]);
      chk("R10 random flag", irq[t], exp[16]);
      wr(3'd1, 8'h00);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule